// File: doc/BRIEF.md
# Single-Input-Change Test Pair Generator

This block is an on-chip stimulus source for built-in self-test of a regular array of identical cells. It emits a 3-bit test word on every functional clock. The word stream is made of vector pairs. During the first phase every pair differs in exactly one bit. During the second phase the word changes in two bits from one test step to the next. The generator moves from the first phase to the second on its own. After the second phase it stops and signals completion.

Inside, a binary counter advances slowly. A one-hot mask rotates once per test step, and a test step lasts two functional clocks. An internal toggle flop stands in for a half-rate test clock, so everything runs on one clock. In the first phase the mask is applied only in the second half of each step. This produces a single-bit change inside each pair. In the second phase the mask is always applied. Patterns start when the enable goes high. Dropping the enable returns the generator to its start state.

Top module: `sicg_pair_gen`

## Requirements
- R1: While rst_n is low, the test word, the phase flag and the done flag are all 0.
- R2: While bist_en is low, the test word is 0. An enable-low clock edge returns all internal state to its start values.
- R3: A test step lasts two clocks, and the half bit alternates 0,1 starting at 0. In phase one, the word equals the counter value in the first clock of a step. In the second clock it equals the counter XOR the mask.
- R4: The mask is one-hot and starts at 001. It rotates toward bit 0 once per test step, with bit 0 wrapping to bit 2: 001, 100, 010, 001.
- R5: The counter starts at 000 and advances by one every six test steps (twelve clocks). It visits all eight values, then wraps from 111 to 000.
- R6: The phase flag rises exactly 96 enabled clocks after the start, when the counter wraps in phase one. A clear of the enable in that same cycle leaves the flag at 0.
- R7: In phase two, the word equals the counter XOR the mask in both clocks of every step.
- R8: In phase one, the two words of a step differ in exactly one bit. In phase two, the words of consecutive steps that share a counter value differ in exactly two bits.
- R9: The done flag rises 192 enabled clocks after the start. From then on, while enabled, the word stays 0 and the done and phase flags stay 1.
- R10: A later low-then-high enable restarts the whole sequence from its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bist_en | input | 1 | Runs the generator while high; clears it when low |
| tpat_o | output | 3 | Test word |
| dual_phase_o | output | 1 | 1 once the generator is in the two-bit-change phase |
| sweep_done_o | output | 1 | 1 once both phases have finished |

## Verification
Several events can land on the same clock edge. The counter wrap from 111 coincides with the phase switch, and later with the done flag. The bench also drops the enable on exactly the edge where the phase would switch. The check is that the clear wins: the phase flag stays 0 and the sequence restarts from its first word. A scoreboard compares every cycle against a model built from the step count alone. The bench also measures pair distances and which counter values are visited.

// File: rtl/sicg_pkg.sv
// Shared types for the single-input-change pair generator.
// Assumes nothing beyond the enum below.
package sicg_pkg;
    typedef enum logic {
        PH_SINGLE = 1'b0,
        PH_DOUBLE = 1'b1
    } sicg_phase_e;
endpackage

// File: rtl/sicg_half_rate.sv
// Half-rate test clock model: a toggle flop that splits every test step
// into a first half (0) and a second half (1).
// Assumes a single functional clock; holds its value once hold is high.
module sicg_half_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hold,
    output logic half_o
);
    logic half_q;

    // Toggle once per enabled clock; clear on reset or enable drop.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_q <= 1'b0;
        else if (!en)    half_q <= 1'b0;
        else if (!hold)  half_q <= ~half_q;
    end

    assign half_o = half_q;
endmodule

// File: rtl/sicg_mask_ring.sv
// One-hot rotating mask: starts at bit 0 and rotates toward bit 0 by one
// place per test step, with the low bit wrapping to the top.
// Assumes step is a single-cycle pulse once per test step.
module sicg_mask_ring #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    output logic [W-1:0] mask_o
);
    localparam logic [W-1:0] MASK_INIT = W'(1);

    logic [W-1:0] ring_q;

    // Rotate right on each step; reload the start value on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     ring_q <= MASK_INIT;
        else if (!en)   ring_q <= MASK_INIT;
        else if (step)  ring_q <= {ring_q[0], ring_q[W-1:1]};
    end

    assign mask_o = ring_q;
endmodule

// File: rtl/sicg_sweep_ctrl.sv
// Sweep controller: a sub-counter of test steps, the slow binary counter,
// the phase flop and the done flop.
// Assumes step pulses once per test step and stops once done is high.
module sicg_sweep_ctrl
    import sicg_pkg::*;
#(
    parameter int W     = 3,
    parameter int RATIO = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    output logic [W-1:0] cnt_o,
    output sicg_phase_e  phase_o,
    output logic         done_o
);
    localparam int              SUB_W   = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(RATIO - 1);
    localparam logic [W-1:0]     CNT_MAX  = {W{1'b1}};

    logic [SUB_W-1:0] sub_q;
    logic [W-1:0]     cnt_q;
    sicg_phase_e      phase_q;
    logic             done_q;
    logic             wrap;

    assign wrap = step && (sub_q == SUB_LAST);

    // Count steps within one counter value.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  sub_q <= '0;
        else if (wrap)      sub_q <= '0;
        else if (step)      sub_q <= sub_q + 1'b1;
    end

    // Advance the slow counter once per RATIO steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt_q <= '0;
        else if (wrap)      cnt_q <= cnt_q + 1'b1;
    end

    // Move to the double-change phase when the first sweep wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                                       phase_q <= PH_SINGLE;
        else if (wrap && cnt_q == CNT_MAX && phase_q == PH_SINGLE) phase_q <= PH_DOUBLE;
    end

    // Flag completion when the second sweep wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)                                       done_q <= 1'b0;
        else if (wrap && cnt_q == CNT_MAX && phase_q == PH_DOUBLE) done_q <= 1'b1;
    end

    assign cnt_o   = cnt_q;
    assign phase_o = phase_q;
    assign done_o  = done_q;
endmodule

// File: rtl/sicg_pair_gen.sv
// Top of the single-input-change pair generator. It combines the half-rate
// toggle, the mask ring and the sweep controller into the test word.
// Assumes one functional clock and a synchronous active-low reset.
module sicg_pair_gen
    import sicg_pkg::*;
#(
    parameter int W     = 3,
    parameter int RATIO = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bist_en,
    output logic [W-1:0] tpat_o,
    output logic         dual_phase_o,
    output logic         sweep_done_o
);
    logic         half_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] cnt_q;
    sicg_phase_e  phase_q;
    logic         done_q;
    logic         step;

    // A step ends on the second half of the test clock.
    assign step = bist_en && half_q && !done_q;

    sicg_half_rate u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bist_en),
        .hold   (done_q),
        .half_o (half_q)
    );

    sicg_mask_ring #(.W(W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bist_en),
        .step   (step),
        .mask_o (mask_q)
    );

    sicg_sweep_ctrl #(.W(W), .RATIO(RATIO)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (bist_en),
        .step    (step),
        .cnt_o   (cnt_q),
        .phase_o (phase_q),
        .done_o  (done_q)
    );

    // Form the test word from the counter and the (gated) mask.
    always_comb begin
        if (!bist_en || done_q)       tpat_o = '0;
        else if (phase_q == PH_DOUBLE) tpat_o = cnt_q ^ mask_q;
        else                          tpat_o = cnt_q ^ (mask_q & {W{half_q}});
    end

    assign dual_phase_o = (phase_q == PH_DOUBLE);
    assign sweep_done_o = done_q;
endmodule

// File: rtl/sicg_pair_gen_chk.sv
// Property checker for the pair generator, bound to the top module.
// Assumes the internal names of sicg_pair_gen shown in the bind below.
module sicg_pair_gen_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [W-1:0] word,
    input logic [W-1:0] mask,
    input logic [W-1:0] cnt,
    input logic         phase,
    input logic         done
);
    assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == 1);

    assert_cnt_steps_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && cnt != $past(cnt)) |-> (cnt == W'($past(cnt) + 1'b1)));

    assert_phase_rise_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase) |-> (cnt == '0 && !done));

    assert_single_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !phase && !done) |-> ($countones(word ^ cnt) <= 1));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> (done && phase && word == '0));

    assert_clear_on_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !phase && !done));
endmodule

bind sicg_pair_gen sicg_pair_gen_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (bist_en),
    .word  (tpat_o),
    .mask  (mask_q),
    .cnt   (cnt_q),
    .phase (dual_phase_o),
    .done  (sweep_done_o)
);

// File: tb/sicg_pair_gen_tb_top.sv
// Scoreboard bench: the driver advances a step-count model and queues the
// expected outputs; the monitor compares them at the falling edge.
module sicg_pair_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S_PHASE2   = 96;
    localparam int S_DONE     = 192;

    typedef struct {
        int       s;
        bit       en;
        bit [2:0] w;
        bit       ph;
        bit       dn;
        string    note;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bist_en = 1'b1;
    logic [2:0] tpat;
    logic       dual_phase;
    logic       sweep_done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   s_mod = 0;
    bit   finished = 1'b0;
    bit   visited [8];
    string note = "R1";
    exp_t  sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sicg_pair_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bist_en      (bist_en),
        .tpat_o       (tpat),
        .dual_phase_o (dual_phase),
        .sweep_done_o (sweep_done)
    );

    function automatic bit [2:0] mask_of(int b);
        case (b % 3)
            0:       return 3'b001;
            1:       return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    function automatic exp_t model(int s, bit en, string n);
        exp_t e;
        int   b = s / 2;
        bit [2:0] c = 3'((b / 6) % 8);
        e.s = s; e.en = en; e.note = n;
        e.ph = (s >= S_PHASE2);
        e.dn = (s >= S_DONE);
        if (!en || e.dn)      e.w = 3'b000;
        else if (e.ph)        e.w = c ^ mask_of(b);
        else if (s % 2 == 1)  e.w = c ^ mask_of(b);
        else                  e.w = c;
        return e;
    endfunction

    task automatic check(bit ok, string req, int act, int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Driver: one clock edge, model update, next inputs, expected item.
    task automatic step(bit nxt_en, bit nxt_rst);
        exp_t e;
        @(posedge clk);
        if (!rst_n || !bist_en)  s_mod = 0;
        else if (s_mod < S_DONE) s_mod++;
        #1;
        bist_en = nxt_en;
        rst_n   = nxt_rst;
        e = model(s_mod, nxt_en, note);
        if (!nxt_rst) e.note = "R1";
        else if (!nxt_en && note == "") e.note = "R2";
        else if (note == "") e.note = (s_mod >= S_DONE) ? "R9" : (s_mod >= S_PHASE2) ? "R7" : "R3";
        sb_q.push_back(e);
    endtask

    // Monitor: compare against the queue and measure pair distances.
    initial begin
        exp_t     it;
        bit [2:0] p1 = '0, p2 = '0;
        int       s1 = -9, s2 = -9;
        bit       ph_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(tpat == it.w, {it.note, " word"}, tpat, it.w);
                check(dual_phase == it.ph, {it.note, " phase"}, dual_phase, it.ph);
                check(sweep_done == it.dn, {it.note, " done"}, sweep_done, it.dn);
                if (it.en && it.s < S_PHASE2) begin
                    if (it.s % 2 == 0) visited[tpat] = 1'b1;   // R5 counter value
                    if (it.s % 2 == 1 && s1 == it.s - 1) begin
                        check($countones(tpat ^ p1) == 1, "R8 single change", $countones(tpat ^ p1), 1);
                        check((tpat ^ p1) == mask_of(it.s / 2), "R4 mask", tpat ^ p1, mask_of(it.s / 2));
                    end
                end
                if (it.en && it.s >= S_PHASE2 && it.s < S_DONE && it.s % 2 == 0
                    && (it.s / 2) % 6 != 0 && s2 == it.s - 2)
                    check($countones(tpat ^ p2) == 2, "R8 double change", $countones(tpat ^ p2), 2);
                if (it.en && it.s == S_PHASE2)
                    check(dual_phase && !ph_prev, "R6 phase rise", dual_phase, 1);
                p2 = p1; s2 = s1;
                p1 = tpat; s1 = it.en ? it.s : -9;
                ph_prev = dual_phase;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b1, 1'b0);                 // R1 reset
        note = "R2";
        repeat (4) step(1'b0, 1'b1);                 // R2 enable low
        note = "";
        repeat (206) step(1'b1, 1'b1);               // full run: R3 R7 R9
        note = "R10";
        step(1'b0, 1'b1);
        repeat (41) step(1'b1, 1'b1);                // R10 restart
        step(1'b0, 1'b1);
        note = "R6";
        repeat (95) step(1'b1, 1'b1);
        step(1'b0, 1'b1);                            // clear on the switch edge
        note = "R10";
        repeat (11) step(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        for (int v = 0; v < 8; v++)
            check(visited[v], "R5 counter visit", visited[v], 1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule